// File: doc/BRIEF.md
# Page-Buffered Serial Memory Write Controller

This block sits behind a two-wire serial protocol engine and in front of a byte-wide nonvolatile array. It owns the address counter that survives from one transaction to the next, collects incoming write bytes into a one-page buffer, and, when the protocol engine signals the end of a write transaction, replays the buffered bytes into the array as one timed rewrite. For the whole rewrite it raises a busy flag that the protocol engine uses to withhold acknowledges.

The array size is a parameter (128, 256 or 512 bytes); the page is 16 bytes for the 512-byte array and 8 bytes otherwise. Write-byte steps move only the in-page offset, while read steps move the full address and roll over at the top of the array. The two larger sizes honour a strapped protect input that blocks array writes into the upper half of the address space without shortening the busy period. The array is modelled as a register memory and the rewrite time is a clock-cycle count.

Top module: `pgw_ctrl`

## Requirements
- R1: After reset the address counter is 0, `busy_o` and `arr_we_o` are low, and every array byte reads as 0x00.
- R2: A cycle with `addr_load_i` high sets the counter to `addr_val_i`; from the next cycle `rd_data_o` shows the array byte at that address.
- R3: A cycle with `rd_step_i` high (and no load or push) adds one to the whole address, rolling from the last address to 0.
- R4: A cycle with `wr_push_i` high buffers `wr_data_i` at the current in-page offset (low 3 address bits for 8-byte pages, low 4 bits for 16-byte pages) and advances only those bits, wrapping within the page; the upper address bits stay fixed.
- R5: When more bytes than one page are pushed, a later byte replaces the earlier byte at the same offset, and only the last value reaches the array.
- R6: `commit_i` with at least one buffered byte raises `busy_o` from the next cycle for exactly `WRITE_CYCLES` cycles.
- R7: A rewrite issues one array write strobe per buffered offset and leaves all other bytes of the page unchanged.
- R8: `commit_i` with an empty buffer does not raise `busy_o`.
- R9: While `busy_o` is high, load, read-step, push and commit inputs have no effect on the counter, the buffer or the array.
- R10: For 256- and 512-byte arrays, with `wp_i` high at commit and the page in the upper half (address MSB = 1), no array strobe is issued but `busy_o` still lasts `WRITE_CYCLES` cycles; lower-half pages are written normally.
- R11: A load discards any buffered bytes, so a following commit starts no rewrite.
- R12: Priority in a single cycle: load over push over read-step; a push in the same cycle as `commit_i` is included in the rewrite.
- R13: The 128-byte configuration ignores `wp_i` and writes any page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load_i | input | 1 | Load the address counter |
| addr_val_i | input | AW | Address to load |
| rd_step_i | input | 1 | Read byte finished: full-address increment |
| wr_push_i | input | 1 | Write byte received: buffer it and step the page offset |
| wr_data_i | input | 8 | Write byte |
| commit_i | input | 1 | End of write transaction: start the rewrite |
| wp_i | input | 1 | Strapped protect for the upper half |
| rd_data_o | output | 8 | Array byte at the current address |
| busy_o | output | 1 | Rewrite in progress |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | AW | Array write address |
| arr_wdata_o | output | 8 | Array write data |

## Verification
The final data byte of a page and the end-of-transaction commit can arrive in the same cycle; the bench drives a push together with a commit that completes a full wrapped page and then reads the last offset back to show that the byte took part in the rewrite. A load and a read-step are also driven together and the resulting address judged through `rd_data_o`. Inputs presented during the rewrite window are judged by the address held afterwards and by a later commit that must find the buffer empty.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

   typedef logic [7:0] byte_t;

   // Page size follows the array size: 16 bytes for the largest array.
   function automatic int page_bytes_for(input int mem_bytes);
      return (mem_bytes > 256) ? 16 : 8;
   endfunction

   // Only the two larger arrays carry the upper-half protect.
   function automatic bit has_protect(input int mem_bytes);
      return mem_bytes > 128;
   endfunction

endpackage

// File: rtl/pgw_addr_ctr.sv
module pgw_addr_ctr #(
   parameter int AW = 8,
   parameter int OW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          busy_i,
   input  logic          ld_i,
   input  logic [AW-1:0] ld_val_i,
   input  logic          inc_i,
   input  logic          wr_i,
   output logic [AW-1:0] addr_o
);

   logic [AW-1:0] addr_q, addr_d;
   logic [OW-1:0] off_nx;

   assign off_nx = addr_q[OW-1:0] + OW'(1);

   always_comb begin
      addr_d = addr_q;
      if (!busy_i) begin
         if (ld_i)       addr_d = ld_val_i;
         else if (wr_i)  addr_d = {addr_q[AW-1:OW], off_nx};
         else if (inc_i) addr_d = addr_q + AW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) addr_q <= '0;
      else        addr_q <= addr_d;
   end

   assign addr_o = addr_q;

   // R9: counter frozen during a rewrite
   a_r9_hold_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> $stable(addr_q));

   // R4: a pushed byte never moves the page number
   a_r4_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_i && !ld_i && wr_i) |=> addr_q[AW-1:OW] == $past(addr_q[AW-1:OW]));

   // R3: read stepping rolls over at the top
   a_r3_rollover: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_i && !ld_i && !wr_i && inc_i && (&addr_q)) |=> addr_q == '0);

endmodule

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
   parameter int PAGE = 8,
   parameter int OW   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               busy_i,
   input  logic               ld_i,
   input  logic               wr_i,
   input  logic [OW-1:0]      off_i,
   input  pgw_pkg::byte_t     data_i,
   input  logic               clr_i,
   input  logic [OW-1:0]      slot_i,
   output logic               any_nxt_o,
   output logic               slot_valid_o,
   output pgw_pkg::byte_t     slot_data_o
);

   logic [PAGE-1:0] valid_q, valid_d;
   pgw_pkg::byte_t  data_q [PAGE];
   logic            take;

   assign take = !busy_i && !ld_i && wr_i;

   always_comb begin
      valid_d = valid_q;
      if (clr_i)                valid_d = '0;
      else if (!busy_i && ld_i) valid_d = '0;
      else if (take)            valid_d[off_i] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= '0;
      else        valid_q <= valid_d;
   end

   for (genvar g = 0; g < PAGE; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             data_q[g] <= '0;
         else if (take && off_i == OW'(g))       data_q[g] <= data_i;
      end
   end

   assign any_nxt_o    = |valid_d;
   assign slot_valid_o = valid_q[slot_i];
   assign slot_data_o  = data_q[slot_i];

   // R11: a load empties the buffer
   a_r11_load_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_i && ld_i && !clr_i) |=> valid_q == '0);

endmodule

// File: rtl/pgw_rewrite_seq.sv
module pgw_rewrite_seq #(
   parameter int AW           = 8,
   parameter int OW           = 3,
   parameter int PAGE         = 8,
   parameter int WRITE_CYCLES = 40,
   parameter bit HAS_WP       = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               commit_i,
   input  logic               any_i,
   input  logic               wp_i,
   input  logic [AW-OW-1:0]   page_i,
   input  logic               slot_valid_i,
   input  pgw_pkg::byte_t     slot_data_i,
   output logic               busy_o,
   output logic [OW-1:0]      slot_o,
   output logic               clr_o,
   output logic               we_o,
   output logic [AW-1:0]      waddr_o,
   output pgw_pkg::byte_t     wdata_o
);

   localparam int PW = AW - OW;
   localparam int CW = $clog2(WRITE_CYCLES + 1);

   logic [CW-1:0] cnt_q;
   logic          busy_q, lock_q, start, last, prot_now, in_drain;
   logic [PW-1:0] base_q;

   if (HAS_WP) begin : g_wp
      assign prot_now = wp_i & page_i[PW-1];
   end else begin : g_nowp
      assign prot_now = wp_i & 1'b0;
   end

   assign start    = commit_i && !busy_q && any_i;
   assign last     = busy_q && (cnt_q == CW'(WRITE_CYCLES - 1));
   assign in_drain = cnt_q < CW'(PAGE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         base_q <= '0;
         lock_q <= 1'b0;
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
         base_q <= page_i;
         lock_q <= prot_now;
      end else if (busy_q) begin
         if (last) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q  <= cnt_q + CW'(1);
         end
      end
   end

   assign busy_o  = busy_q;
   assign clr_o   = last;
   assign slot_o  = cnt_q[OW-1:0];
   assign we_o    = busy_q && in_drain && slot_valid_i && !lock_q;
   assign waddr_o = {base_q, slot_o};
   assign wdata_o = slot_data_i;

   // R6: busy window starts at count zero and ends after the full count
   a_r6_busy_starts: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> cnt_q == '0);
   a_r6_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> $past(cnt_q) == CW'(WRITE_CYCLES - 1));

   // R8: an empty commit never starts a rewrite
   a_r8_empty_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && !busy_q && !any_i) |=> !busy_q);

endmodule

// File: rtl/pgw_array.sv
module pgw_array #(
   parameter int DEPTH = 256,
   parameter int AW    = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we_i,
   input  logic [AW-1:0]   waddr_i,
   input  pgw_pkg::byte_t  wdata_i,
   input  logic [AW-1:0]   raddr_i,
   output pgw_pkg::byte_t  rdata_o
);

   pgw_pkg::byte_t mem_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (we_i) begin
         mem_q[waddr_i] <= wdata_i;
      end
   end

   assign rdata_o = mem_q[raddr_i];

   // R7: a strobed byte lands in the array
   a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));

endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl #(
   parameter  int MEM_BYTES    = 256,
   parameter  int WRITE_CYCLES = 40,
   localparam int AW           = $clog2(MEM_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          addr_load_i,
   input  logic [AW-1:0] addr_val_i,
   input  logic          rd_step_i,
   input  logic          wr_push_i,
   input  logic [7:0]    wr_data_i,
   input  logic          commit_i,
   input  logic          wp_i,
   output logic [7:0]    rd_data_o,
   output logic          busy_o,
   output logic          arr_we_o,
   output logic [AW-1:0] arr_addr_o,
   output logic [7:0]    arr_wdata_o
);

   localparam int PAGE_BYTES = pgw_pkg::page_bytes_for(MEM_BYTES);
   localparam int OW         = $clog2(PAGE_BYTES);
   localparam bit HAS_WP     = pgw_pkg::has_protect(MEM_BYTES);

   if (MEM_BYTES != 128 && MEM_BYTES != 256 && MEM_BYTES != 512) begin : g_bad_size
      $error("pgw_ctrl: MEM_BYTES must be 128, 256 or 512");
   end
   if (WRITE_CYCLES < PAGE_BYTES) begin : g_bad_time
      $error("pgw_ctrl: WRITE_CYCLES must cover one page drain");
   end

   logic [AW-1:0]  addr;
   logic           busy, any_nxt, slot_valid, clr;
   logic [OW-1:0]  slot;
   pgw_pkg::byte_t slot_data;

   pgw_addr_ctr #(.AW(AW), .OW(OW)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .busy_i   (busy),
      .ld_i     (addr_load_i),
      .ld_val_i (addr_val_i),
      .inc_i    (rd_step_i),
      .wr_i     (wr_push_i),
      .addr_o   (addr)
   );

   pgw_page_buf #(.PAGE(PAGE_BYTES), .OW(OW)) u_buf (
      .clk          (clk),
      .rst_n        (rst_n),
      .busy_i       (busy),
      .ld_i         (addr_load_i),
      .wr_i         (wr_push_i),
      .off_i        (addr[OW-1:0]),
      .data_i       (wr_data_i),
      .clr_i        (clr),
      .slot_i       (slot),
      .any_nxt_o    (any_nxt),
      .slot_valid_o (slot_valid),
      .slot_data_o  (slot_data)
   );

   pgw_rewrite_seq #(
      .AW(AW), .OW(OW), .PAGE(PAGE_BYTES),
      .WRITE_CYCLES(WRITE_CYCLES), .HAS_WP(HAS_WP)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .commit_i     (commit_i),
      .any_i        (any_nxt),
      .wp_i         (wp_i),
      .page_i       (addr[AW-1:OW]),
      .slot_valid_i (slot_valid),
      .slot_data_i  (slot_data),
      .busy_o       (busy),
      .slot_o       (slot),
      .clr_o        (clr),
      .we_o         (arr_we_o),
      .waddr_o      (arr_addr_o),
      .wdata_o      (arr_wdata_o)
   );

   pgw_array #(.DEPTH(MEM_BYTES), .AW(AW)) u_arr (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (arr_we_o),
      .waddr_i (arr_addr_o),
      .wdata_i (arr_wdata_o),
      .raddr_i (addr),
      .rdata_o (rd_data_o)
   );

   assign busy_o = busy;

   // R10: with protect strapped high, no strobe reaches the upper half
   a_r10_upper_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_WP && wp_i && arr_we_o) |-> !arr_addr_o[AW-1]);

   // R1: strobes only inside a rewrite
   a_r1_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we_o |-> busy_o);

endmodule

// File: tb/pgw_ctrl_test.sv
module pgw_ctrl_test;

   localparam int WC = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   // 256-byte instance
   logic       ld = 0, inc = 0, wr = 0, cm = 0, wp = 0;
   logic [7:0] av = 0, wd = 0;
   logic [7:0] rd, aa, awd;
   logic       busy, we;

   pgw_ctrl #(.MEM_BYTES(256), .WRITE_CYCLES(WC)) uut (
      .clk(clk), .rst_n(rst_n), .addr_load_i(ld), .addr_val_i(av),
      .rd_step_i(inc), .wr_push_i(wr), .wr_data_i(wd), .commit_i(cm),
      .wp_i(wp), .rd_data_o(rd), .busy_o(busy), .arr_we_o(we),
      .arr_addr_o(aa), .arr_wdata_o(awd)
   );

   // 128-byte instance
   logic       s_ld = 0, s_wr = 0, s_cm = 0, s_wp = 0;
   logic [6:0] s_av = 0, s_aa;
   logic [7:0] s_wd = 0, s_rd, s_awd;
   logic       s_busy, s_we;

   pgw_ctrl #(.MEM_BYTES(128), .WRITE_CYCLES(WC)) uut_1k (
      .clk(clk), .rst_n(rst_n), .addr_load_i(s_ld), .addr_val_i(s_av),
      .rd_step_i(1'b0), .wr_push_i(s_wr), .wr_data_i(s_wd), .commit_i(s_cm),
      .wp_i(s_wp), .rd_data_o(s_rd), .busy_o(s_busy), .arr_we_o(s_we),
      .arr_addr_o(s_aa), .arr_wdata_o(s_awd)
   );

   int checks = 0, fails = 0, we_cnt = 0, n;
   bit done = 0;

   always @(posedge clk) if (we) we_cnt <= we_cnt + 1;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input logic l, input logic [7:0] a, input logic i,
                       input logic w, input logic [7:0] d, input logic c);
      @(negedge clk);
      ld = l; av = a; inc = i; wr = w; wd = d; cm = c;
      @(negedge clk);
      ld = 0; inc = 0; wr = 0; cm = 0;
   endtask

   task automatic run_busy(output int cnt);
      cnt = 0;
      while (busy && cnt < 1000) begin
         cnt++;
         @(negedge clk);
      end
   endtask

   task automatic read_at(input logic [7:0] a, input string req, input int exp);
      step(1, a, 0, 0, 0, 0);
      check(req, rd, exp);
   endtask

   // {op (0 load / 1 step), address, expected byte}
   localparam logic [16:0] VEC [8] = '{
      {1'b0, 8'hFC, 8'hA6}, {1'b1, 8'h00, 8'hA7}, {1'b1, 8'h00, 8'hA4},
      {1'b1, 8'h00, 8'hA5}, {1'b1, 8'h00, 8'h5A}, {1'b1, 8'h00, 8'h5B},
      {1'b0, 8'hF8, 8'hA2}, {1'b0, 8'h01, 8'h5B}
   };

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 rd", rd, 0);
      check("R1 busy", busy, 0);
      check("R1 we", we, 0);
      rst_n = 1;
      @(negedge clk);

      // fill page F8 with a^5A, measure busy and strobes (R6, R7)
      step(1, 8'hF8, 0, 0, 0, 0);
      for (int k = 0; k < 8; k++) step(0, 0, 0, 1, 8'(8'hF8 + k) ^ 8'h5A, 0);
      we_cnt = 0;
      step(0, 0, 0, 0, 0, 1);
      check("R6 busy rises", busy, 1);
      run_busy(n);
      check("R6 busy length", n, WC);
      check("R7 strobes full page", we_cnt, 8);
      step(1, 8'h00, 0, 0, 0, 0);
      for (int k = 0; k < 8; k++) step(0, 0, 0, 1, 8'(k) ^ 8'h5A, 0);
      step(0, 0, 0, 0, 0, 1);
      run_busy(n);

      // table walk: loads (R2) and read steps with rollover (R3)
      for (int v = 0; v < 8; v++) begin
         step(!VEC[v][16], VEC[v][15:8], VEC[v][16], 0, 0, 0);
         check(VEC[v][16] ? "R3 read step" : "R2 load", rd, VEC[v][7:0]);
      end

      // R4/R5: ten bytes into an 8-byte page
      step(1, 8'h40, 0, 0, 0, 0);
      for (int k = 0; k < 10; k++) step(0, 0, 0, 1, 8'(8'h10 + k), 0);
      step(0, 0, 0, 0, 0, 1);
      run_busy(n);
      check("R4 offset wrapped, page fixed", rd, 8'h12);
      read_at(8'h40, "R5 overwrite off0", 8'h18);
      read_at(8'h41, "R5 overwrite off1", 8'h19);
      read_at(8'h47, "R4 last offset", 8'h17);
      step(0, 0, 1, 0, 0, 0);
      check("R4 next page untouched", rd, 8'h00);

      // R7: partial page leaves other bytes alone
      step(1, 8'h60, 0, 0, 0, 0);
      for (int k = 0; k < 8; k++) step(0, 0, 0, 1, 8'h11, 0);
      step(0, 0, 0, 0, 0, 1);
      run_busy(n);
      step(1, 8'h63, 0, 0, 0, 0);
      step(0, 0, 0, 1, 8'hAA, 0);
      step(0, 0, 0, 1, 8'hBB, 0);
      we_cnt = 0;
      step(0, 0, 0, 0, 0, 1);
      run_busy(n);
      check("R7 two strobes", we_cnt, 2);
      read_at(8'h62, "R7 below", 8'h11);
      read_at(8'h63, "R7 first", 8'hAA);
      read_at(8'h64, "R7 second", 8'hBB);
      read_at(8'h65, "R7 above", 8'h11);

      // R8: empty commit
      step(1, 8'h10, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 1);
      check("R8 empty commit", busy, 0);

      // R12: last push with commit; R9: inputs during busy
      step(1, 8'h50, 0, 0, 0, 0);
      for (int k = 0; k < 7; k++) step(0, 0, 0, 1, 8'(k + 1), 0);
      step(0, 0, 0, 1, 8'h08, 1);
      check("R12 push+commit starts", busy, 1);
      step(1, 8'h00, 0, 0, 0, 0);
      step(0, 0, 1, 0, 0, 0);
      step(0, 0, 0, 1, 8'h99, 0);
      step(0, 0, 0, 0, 0, 1);
      run_busy(n);
      check("R9 address held", rd, 8'h01);
      step(0, 0, 0, 0, 0, 1);
      check("R9 push ignored", busy, 0);
      read_at(8'h57, "R12 same-cycle byte written", 8'h08);
      step(1, 8'h40, 1, 0, 0, 0);
      check("R12 load beats step", rd, 8'h18);

      // R10: protect
      wp = 1;
      step(1, 8'h80, 0, 0, 0, 0);
      step(0, 0, 0, 1, 8'h77, 0);
      we_cnt = 0;
      step(0, 0, 0, 0, 0, 1);
      run_busy(n);
      check("R10 busy still full", n, WC);
      check("R10 no strobe", we_cnt, 0);
      read_at(8'h80, "R10 upper unchanged", 8'h00);
      step(1, 8'h7F, 0, 0, 0, 0);
      step(0, 0, 0, 1, 8'h33, 0);
      step(0, 0, 0, 0, 0, 1);
      run_busy(n);
      read_at(8'h7F, "R10 lower written", 8'h33);
      wp = 0;

      // R11: load drops buffer
      step(1, 8'h30, 0, 0, 0, 0);
      step(0, 0, 0, 1, 8'h44, 0);
      step(1, 8'h31, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 1);
      check("R11 no rewrite", busy, 0);
      read_at(8'h30, "R11 byte dropped", 8'h00);

      // R13: 128-byte array ignores protect
      @(negedge clk); s_wp = 1; s_ld = 1; s_av = 7'h70;
      @(negedge clk); s_ld = 0; s_wr = 1; s_wd = 8'h66;
      @(negedge clk); s_wr = 0; s_cm = 1;
      @(negedge clk); s_cm = 0;
      check("R13 busy", s_busy, 1);
      n = 0;
      while (s_busy && n < 1000) begin n++; @(negedge clk); end
      s_ld = 1; s_av = 7'h70;
      @(negedge clk); s_ld = 0;
      check("R13 upper written", s_rd, 8'h66);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule